// File: doc/BRIEF.md
# Synchronized Clock Stop Gate

This block gates a group of clock outputs that are made in the system clock domain. A strobe input `tick` sets the half-period: a shared phase register flips on every strobe. Each output copies that phase while its gate is open. A stop request comes either from an asynchronous active-low pin, which passes through a synchronizer, or from a software stop bit. A select input picks which of the two is used. Outputs whose free-run bit is set ignore the request. Every output also has an enable bit that forces it low.

The gate opens and closes only at rise events, which are strobes on which the phase goes from low to high. A stopped output therefore parks low and never shows a runt pulse, and its first high phase after a restart has full width. The stop latency, the restart latency and the minimum run time between stops are parameters. The defaults give the tighter group: stop on the first rise, restart on the third rise, and at least ten delivered high phases between stops. The looser group sets all three to other values.

Top module: `clk_stop_gate`

## Requirements
- R1: `stop_pin_n` is active low and is used only after SYNC_STAGES synchronizer flops. A pin change made one clock after a rise event takes effect at the next rise event.
- R2: A gated output that is stopped stays at 0. A gated output is never high while the phase is low, so a stop never cuts a high phase short.
- R3: Every high phase of a gated output lasts exactly one full half-period, the first one after a restart included.
- R4: While the stop request is active and the run interval has been met, the OFF_LAT-th rise event after the request is seen is the first one suppressed. With the default OFF_LAT=1, that is the very next rise.
- R5: After the request is released, the first delivered high phase starts at the ON_LAT-th rise event (default 3). If the request comes back during this count, the count restarts.
- R6: After a restart, at least MIN_ON high phases are delivered (the first one included) before a new stop takes effect. A request that arrives earlier is held and acts as soon as that count is reached.
- R7: An output whose `free_run` bit is 1 follows the phase on every cycle whatever the request is. Its waveform equals that of any other free-running output.
- R8: When `src_hw`=1 the pin requests the stop, and when `src_hw`=0 the software bit `sw_stop_n` requests it when it is 0. The source that is not selected has no effect on the outputs.
- R9: An output whose `out_en` bit is 0 is 0 from the next clock on, free-running or not.
- R10: While `rst_n` is low, all outputs are 0, the phase is low, the gate is open and the run interval counts as met.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| tick | input | 1 | Half-period strobe; the phase flips on each one |
| stop_pin_n | input | 1 | Asynchronous active-low stop request |
| sw_stop_n | input | 1 | Software stop bit, requests a stop when 0 |
| src_hw | input | 1 | 1 selects the pin as the request source, 0 selects the software bit |
| free_run | input | N_OUT | 1 exempts that output from stopping |
| out_en | input | N_OUT | 0 forces that output low |
| clk_out | output | N_OUT | Gated clock outputs |

## Verification
The bench builds the block with its defaults: four outputs, two synchronizer flops, stop latency 1, restart latency 3 and a run interval of 10. Two outputs are marked free-running and two are gated. The strobe comes every fourth clock. This gives a pin change made one clock after a rise enough time to clear the synchronizer before the next rise event, so both latencies can be counted exactly against a free-running output. A run of ten highs is short enough to drive a held early stop all the way to its release, and then to follow that with random pin activity.

// File: rtl/clk_stop_gate.sv
module clk_stop_gate #(
  parameter int N_OUT       = 4,
  parameter int SYNC_STAGES = 2,
  parameter int OFF_LAT     = 1,
  parameter int ON_LAT      = 3,
  parameter int MIN_ON      = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             stop_pin_n,
  input  logic             sw_stop_n,
  input  logic             src_hw,
  input  logic [N_OUT-1:0] free_run,
  input  logic [N_OUT-1:0] out_en,
  output logic [N_OUT-1:0] clk_out
);
  localparam int LAT_MAX = (OFF_LAT > ON_LAT) ? OFF_LAT : ON_LAT;
  localparam int LW      = $clog2(LAT_MAX + 1);
  localparam int MW      = $clog2(MIN_ON + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   ph_q, gate_q;
  logic [LW-1:0]          lat_q;
  logic [MW-1:0]          min_q;

  logic          ph_d, gate_d, stop_req, rise_ev;
  logic [LW-1:0] lat_d;
  logic [MW-1:0] min_d;

  assign stop_req = src_hw ? ~sync_q[SYNC_STAGES-1] : ~sw_stop_n;
  assign rise_ev  = tick & ~ph_q;
  assign ph_d     = tick ? ~ph_q : ph_q;

  always_comb begin
    gate_d = gate_q;
    lat_d  = lat_q;
    min_d  = min_q;
    if (rise_ev) begin
      if (gate_q) begin
        if (stop_req) begin
          if (lat_q == LW'(OFF_LAT - 1) && min_q >= MW'(MIN_ON)) begin
            gate_d = 1'b0;
            lat_d  = '0;
          end else if (lat_q != LW'(OFF_LAT - 1)) begin
            lat_d = lat_q + 1'b1;
          end
        end else begin
          lat_d = '0;
        end
        if (gate_d && min_q != MW'(MIN_ON)) min_d = min_q + 1'b1;
      end else begin
        if (stop_req) begin
          lat_d = '0;
        end else if (lat_q == LW'(ON_LAT - 1)) begin
          gate_d = 1'b1;
          lat_d  = '0;
          min_d  = MW'(1);
        end else begin
          lat_d = lat_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q  <= '1;
      ph_q    <= 1'b0;
      gate_q  <= 1'b1;
      lat_q   <= '0;
      min_q   <= MW'(MIN_ON);
      clk_out <= '0;
    end else begin
      sync_q  <= {sync_q[SYNC_STAGES-2:0], stop_pin_n};
      ph_q    <= ph_d;
      gate_q  <= gate_d;
      lat_q   <= lat_d;
      min_q   <= min_d;
      clk_out <= out_en & {N_OUT{ph_d}} & (free_run | {N_OUT{gate_d}});
    end
  end

  a_r3_open_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_q) |-> ph_q && $past(!ph_q));

  a_r2_close_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gate_q) |-> ph_q && $past(!ph_q));

  a_r2_parked_low: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_q |-> (clk_out & ~$past(free_run)) == '0);

  a_r7_free_follow: assert property (@(posedge clk) disable iff (!rst_n)
    ((clk_out ^ {N_OUT{ph_q}}) & $past(free_run & out_en)) == '0);

  a_r9_disabled_low: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_out & ~$past(out_en)) == '0);

  a_r6_min_run: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gate_q) |-> $past(min_q) >= MW'(MIN_ON));

  a_r1_sync_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stop_pin_n) |-> sync_q[0]);
endmodule

// File: tb/clk_stop_gate_bench.sv
`timescale 1ns/1ps
module clk_stop_gate_bench;
  localparam int N = 4, OFF_LAT = 1, ON_LAT = 3, MIN_ON = 10, HALF = 4;

  logic clk = 0, rst_n = 0, tick = 0, pin_n = 1, sw_n = 1, src_hw = 1;
  logic [N-1:0] free_run = 4'b1001, out_en = 4'hF, clk_out;
  int errs = 0, checks = 0, tcnt = 0;
  int rc [N];
  int hl [N];
  logic [N-1:0] prev = '0;
  bit eq_chk = 0, done = 0;

  clk_stop_gate u_clk_stop_gate (.clk(clk), .rst_n(rst_n), .tick(tick),
    .stop_pin_n(pin_n), .sw_stop_n(sw_n), .src_hw(src_hw),
    .free_run(free_run), .out_en(out_en), .clk_out(clk_out));

  always #2 clk = ~clk;

  always @(negedge clk) begin
    tcnt <= (tcnt == HALF - 1) ? 0 : tcnt + 1;
    tick <= (tcnt == HALF - 1);
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    for (int i = 0; i < N; i++) begin
      if (clk_out[i] && !prev[i]) rc[i]++;
      if (clk_out[i]) hl[i]++;
      if (!clk_out[i] && prev[i]) begin
        if (i == 1 || i == 2) chk(hl[i] == HALF, "R3 high width", hl[i], HALF);
        hl[i] = 0;
      end
    end
    if (clk_out[1] && !clk_out[0]) chk(0, "R2 gated high in low phase", 1, 0);
    if (eq_chk) chk(clk_out[3] == clk_out[0], "R7 free outputs differ", clk_out[3], clk_out[0]);
    prev = clk_out;
  end

  task automatic cyc(); @(posedge clk); #1; endtask

  task automatic wait_ref(input int n);
    int s = rc[0];
    while (rc[0] < s + n) cyc();
  endtask

  task automatic sync_rise(); wait_ref(1); endtask

  task automatic meas_on(input string req);
    int s0, s1;
    s0 = rc[0]; s1 = rc[1];
    while (rc[1] == s1) cyc();
    chk(rc[0] - s0 == ON_LAT, req, rc[0] - s0, ON_LAT);
  endtask

  initial begin
    int s1, s3;
    for (int i = 0; i < N; i++) begin rc[i] = 0; hl[i] = 0; end
    void'($urandom(32'd1234));
    repeat (6) cyc();
    chk(clk_out == '0, "R10 outputs in reset", clk_out, 0);
    rst_n = 1;
    cyc();
    chk(clk_out == '0, "R10 outputs after reset", clk_out, 0);
    eq_chk = 1;

    s1 = rc[1]; wait_ref(20);
    chk(rc[1] - s1 == 20, "R8 pin high no stop", rc[1] - s1, 20);

    sync_rise(); pin_n = 0; s1 = rc[1]; s3 = rc[3];
    wait_ref(OFF_LAT + 2);
    chk(rc[1] - s1 == OFF_LAT - 1, "R4 R1 off latency", rc[1] - s1, OFF_LAT - 1);
    chk(clk_out[2:1] == 2'b00, "R2 parked low", clk_out[2:1], 0);
    chk(rc[3] - s3 == OFF_LAT + 2, "R7 free output runs", rc[3] - s3, OFF_LAT + 2);

    sync_rise(); pin_n = 1;
    meas_on("R5 on latency");
    s1 = rc[1] - 1;
    pin_n = 0;
    wait_ref(MIN_ON + 5);
    chk(rc[1] - s1 == MIN_ON, "R6 minimum run", rc[1] - s1, MIN_ON);
    chk(clk_out[1] == 1'b0, "R2 parked after held stop", clk_out[1], 0);

    pin_n = 1; wait_ref(ON_LAT + MIN_ON + 2);
    src_hw = 0; pin_n = 0; s1 = rc[1];
    wait_ref(6);
    chk(rc[1] - s1 == 6, "R8 pin ignored when software selected", rc[1] - s1, 6);
    sync_rise(); sw_n = 0; s1 = rc[1];
    wait_ref(3);
    chk(rc[1] - s1 == 0, "R8 software stop", rc[1] - s1, 0);
    sync_rise(); sw_n = 1;
    meas_on("R5 on latency software");

    wait_ref(MIN_ON + 2);
    sw_n = 0; src_hw = 1; pin_n = 1; s1 = rc[1];
    wait_ref(6);
    chk(rc[1] - s1 == 6, "R8 software bit ignored when pin selected", rc[1] - s1, 6);
    sw_n = 1;

    eq_chk = 0; out_en[3] = 0; s3 = rc[3];
    cyc(); cyc();
    s3 = rc[3];
    wait_ref(4);
    chk(rc[3] - s3 == 0, "R9 disabled free output", rc[3] - s3, 0);
    chk(clk_out[3] == 1'b0, "R9 disabled output low", clk_out[3], 0);
    out_en[3] = 1; wait_ref(2); eq_chk = 1;

    for (int k = 0; k < 40; k++) begin
      pin_n = $urandom_range(0, 1);
      repeat ($urandom_range(4, 120)) cyc();
    end
    pin_n = 1;
    wait_ref(ON_LAT + 1);
    s1 = rc[1];
    wait_ref(3);
    chk(rc[1] - s1 == 3, "R5 running after random release", rc[1] - s1, 3);

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      errs++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule